// File: doc/BRIEF.md
# 8-bit timer/counter with dual compare and PWM

This block is an 8-bit timer/counter with two compare channels, A and B. It counts on a one-cycle enable that comes from one of two places. The first is a tick input fed by an external prescaler. The second is an external pin, which is synchronized and then edge-detected on a rising or a falling edge. The counter has four operating modes:

- free-running with wrap-around;
- clear-on-compare, where channel A sets the period;
- phase-correct PWM with a fixed ceiling of 0xFF;
- phase-correct PWM with its ceiling taken from channel A.

Each channel drives its own waveform pin and raises its own event flag. An overflow event makes a third flag. A mask selects which flags reach the single interrupt line.

Software reaches the block through a flat register port. Writes are synchronous. Reads are combinational from `rd_addr`. The register map is:

| Address | Register | Contents |
|---|---|---|
| 0 | counter | counter value |
| 1 | compare A | channel A compare value |
| 2 | compare B | channel B compare value |
| 3 | control | mode in bits [1:0], clock source in bits [3:2] |
| 4 | flags | bit0 overflow, bit1 match A, bit2 match B |
| 5 | mask | same bit layout as flags |

The counter direction is held by a two-state machine, `DIR_UP` and `DIR_DOWN`. Its transitions are:

- `UP_TO_DOWN`: a tick at the ceiling in a PWM mode.
- `DOWN_TO_UP`: a tick that reaches zero while counting down.
- `FORCE_UP`: any cycle in a non-PWM mode.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset, every readable register (addresses 0..5) reads 0. Both waveform outputs and `irq` are 0.
- R2: The clock source field is control bits [3:2]. Value 0 stops the counter. Value 1 advances it by one for each `presc_tick` cycle.
- R3: Clock source value 2 counts rising edges of `ext_clk` and value 3 counts falling edges. Each edge is counted once, after a two-stage synchronizer. While an external source is selected, `presc_tick` has no effect.
- R4: In free-running mode (mode 0), the counter wraps from 0xFF to 0x00 and sets flag bit0.
- R5: In clear-on-compare mode (mode 1), a tick with the counter equal to compare A loads 0. The same tick sets flag bit1 and toggles `wave_a`.
- R6: In modes 0 and 1, a tick with the counter equal to compare B sets flag bit2 and toggles `wave_b`.
- R7: In PWM modes the counter counts up to a ceiling, then down to 0, and sets flag bit0 when it reaches 0. The ceiling is 0xFF in mode 2 and compare A in mode 3.
- R8: In PWM modes, a match while counting up drives the channel output to 0. A match while counting down drives it to 1.
- R9: In PWM modes, a compare write reads back at once but takes effect only on a tick at the ceiling. In modes 0 and 1 it takes effect immediately.
- R10: Writing 1 to a flag bit clears it. `irq` is 1 exactly when some flag is set together with its mask bit.
- R11: After a software write to the counter, the next tick raises no match flag and changes no waveform output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_tick | input | 1 | One-cycle count enable from the prescaler |
| ext_clk | input | 1 | Asynchronous external count pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq | output | 1 | Masked OR of the three flags |

## Verification
The bench builds the block at its defaults: an 8-bit counter and a two-stage synchronizer.

The 8-bit width makes wrap-around and the fixed 0xFF ceiling reachable in a few ticks, because the bench writes the counter just below them. The variable ceiling is set to 4, so a whole up-down PWM period, including the buffered compare reload at the ceiling, is covered in about a dozen ticks. With two synchronizer stages, each external edge registers within three cycles, well inside the four-cycle hold the bench applies to each pin level.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_CTC      = 2'd1,
        MODE_PWM_FULL = 2'd2,
        MODE_PWM_VAR  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        CS_OFF      = 2'd0,
        CS_PRESC    = 2'd1,
        CS_EXT_RISE = 2'd2,
        CS_EXT_FALL = 2'd3
    } csel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    localparam logic [2:0] ADR_CNT  = 3'd0;
    localparam logic [2:0] ADR_CMPA = 3'd1;
    localparam logic [2:0] ADR_CMPB = 3'd2;
    localparam logic [2:0] ADR_CTRL = 3'd3;
    localparam logic [2:0] ADR_FLAG = 3'd4;
    localparam logic [2:0] ADR_MASK = 3'd5;
endpackage

// File: rtl/tmr8_clk_sel.sv
module tmr8_clk_sel
    import tmr8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  csel_e csel,
    input  logic  presc_tick,
    input  logic  ext_pin,
    output logic  tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;
    logic                   fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
    assign fall = ~sync_q[SYNC_STAGES-1] & last_q;

    always_comb begin
        unique case (csel)
            CS_OFF:      tick = 1'b0;
            CS_PRESC:    tick = presc_tick;
            CS_EXT_RISE: tick = rise;
            CS_EXT_FALL: tick = fall;
            default:     tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] top_var,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir,
    output logic             load,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dir_e             dir_q, dir_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, top;
    logic             pwm, ctc_hit, step;

    assign pwm     = mode[1];
    assign top     = (mode == MODE_PWM_VAR) ? top_var : '1;
    assign ctc_hit = (mode == MODE_CTC) && (cnt_q == top_var);
    assign step    = tick && !cnt_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_n;
            cnt_q <= cnt_n;
        end
    end

    // next state: FORCE_UP, UP_TO_DOWN, DOWN_TO_UP
    always_comb begin
        dir_n = pwm ? dir_q : DIR_UP;
        cnt_n = cnt_q;
        if (cnt_wr) begin
            cnt_n = cnt_wdata;
        end else if (tick) begin
            unique case (dir_q)
                DIR_UP: begin
                    if (pwm) begin
                        if (cnt_q >= top) begin
                            if (top != '0) begin
                                dir_n = DIR_DOWN;
                                cnt_n = cnt_q - ONE;
                            end
                        end else begin
                            cnt_n = cnt_q + ONE;
                        end
                    end else if (ctc_hit) begin
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (!pwm) begin
                        cnt_n = cnt_q + ONE;
                    end else if (cnt_q <= ONE) begin
                        dir_n = DIR_UP;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q - ONE;
                    end
                end
                default: dir_n = DIR_UP;
            endcase
        end
    end

    // outputs
    always_comb begin
        load = 1'b0;
        ovf  = 1'b0;
        if (step) begin
            unique case (dir_q)
                DIR_UP: begin
                    load = pwm && (cnt_q >= top);
                    ovf  = !pwm && (cnt_q == '1) && !ctc_hit;
                end
                DIR_DOWN: ovf = pwm ? (cnt_q <= ONE) : (cnt_q == '1);
                default: ;
            endcase
        end
    end

    assign cnt = cnt_q;
    assign dir = dir_q;
endmodule

// File: rtl/tmr8_cmp_unit.sv
module tmr8_cmp_unit
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             pwm,
    input  logic             load,
    input  logic             tick,
    input  logic             block,
    input  logic [CNT_W-1:0] cnt,
    input  dir_e             dir,
    output logic [CNT_W-1:0] buf_val,
    output logic [CNT_W-1:0] act_val,
    output logic             match,
    output logic             wave
);
    logic [CNT_W-1:0] buf_q, act_q;
    logic             wave_q;

    assign match = tick && !block && (cnt == act_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            act_q  <= '0;
            wave_q <= 1'b0;
        end else begin
            if (wr) buf_q <= wdata;
            if (!pwm)      act_q <= wr ? wdata : buf_q;
            else if (load) act_q <= buf_q;
            if (match) wave_q <= pwm ? (dir == DIR_DOWN) : ~wave_q;
        end
    end

    assign buf_val = buf_q;
    assign act_val = act_q;
    assign wave    = wave_q;
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             presc_tick,
    input  logic             ext_clk,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             wave_a,
    output logic             wave_b,
    output logic             irq
);
    localparam int NCH = 2;

    logic [3:0]       ctrl_q;
    logic [2:0]       flags_q, mask_q, flag_set;
    logic             blk_q, tick, cnt_wr, flags_wr, load, ovf;
    logic [CNT_W-1:0] cnt_q;
    dir_e             dir;
    mode_e            mode;
    logic [CNT_W-1:0] cmp_buf [NCH];
    logic [CNT_W-1:0] cmp_act [NCH];
    logic [NCH-1:0]   match, wave;

    assign mode     = mode_e'(ctrl_q[1:0]);
    assign cnt_wr   = wr_en && (wr_addr == ADR_CNT);
    assign flags_wr = wr_en && (wr_addr == ADR_FLAG);

    tmr8_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk_sel (
        .clk(clk), .rst_n(rst_n), .csel(csel_e'(ctrl_q[3:2])),
        .presc_tick(presc_tick), .ext_pin(ext_clk), .tick(tick)
    );

    tmr8_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .top_var(cmp_act[0]), .cnt_wr(cnt_wr), .cnt_wdata(wr_data),
        .cnt(cnt_q), .dir(dir), .load(load), .ovf(ovf)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [2:0] ADR_CH = ADR_CMPA + 3'(g);
        tmr8_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_en && (wr_addr == ADR_CH)), .wdata(wr_data),
            .pwm(mode[1]), .load(load), .tick(tick),
            .block(blk_q || cnt_wr), .cnt(cnt_q), .dir(dir),
            .buf_val(cmp_buf[g]), .act_val(cmp_act[g]),
            .match(match[g]), .wave(wave[g])
        );
    end

    assign flag_set = {match[1], match[0], ovf};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            flags_q <= '0;
            mask_q  <= '0;
            blk_q   <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADR_CTRL) ctrl_q <= wr_data[3:0];
            if (wr_en && wr_addr == ADR_MASK) mask_q <= wr_data[2:0];
            flags_q <= (flags_q & ~(flags_wr ? wr_data[2:0] : 3'b000)) | flag_set;
            if (cnt_wr)    blk_q <= 1'b1;
            else if (tick) blk_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADR_CNT:  rd_data = cnt_q;
            ADR_CMPA: rd_data = cmp_buf[0];
            ADR_CMPB: rd_data = cmp_buf[1];
            ADR_CTRL: rd_data = CNT_W'(ctrl_q);
            ADR_FLAG: rd_data = CNT_W'(flags_q);
            ADR_MASK: rd_data = CNT_W'(mask_q);
            default:  rd_data = '0;
        endcase
    end

    assign wave_a = wave[0];
    assign wave_b = wave[1];
    assign irq    = |(flags_q & mask_q);
endmodule

// File: rtl/tmr8_pwm_chk.sv
module tmr8_pwm_chk
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       mode,
    input logic             dir,
    input logic [CNT_W-1:0] act_a,
    input logic             match_a,
    input logic             load,
    input logic             wave_a,
    input logic             flags_wr,
    input logic [2:0]       flags_wdata,
    input logic [2:0]       flag_set,
    input logic [2:0]       flags
);
    logic [CNT_W-1:0] top;
    assign top = (mode == 2'd3) ? act_a : '1;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    assert_ctc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && tick && !cnt_wr && dir == 1'b0 && cnt == act_a) |=> (cnt == '0));

    assert_pwm_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && tick && !cnt_wr && dir == 1'b0 && cnt < top) |=> (cnt == $past(cnt) + 1'b1));

    assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !load) |=> $stable(act_a));

    assert_wave_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && match_a && dir == 1'b0) |=> !wave_a);

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_wr && flags_wdata == 3'b111 && flag_set == 3'b000) |=> (flags == 3'b000));
endmodule

bind tmr8_pwm tmr8_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt(cnt_q),
    .mode(ctrl_q[1:0]), .dir(dir), .act_a(cmp_act[0]), .match_a(match[0]),
    .load(load), .wave_a(wave[0]), .flags_wr(flags_wr),
    .flags_wdata(wr_data[2:0]), .flag_set(flag_set), .flags(flags_q)
);

// File: tb/tb_tmr8_pwm.sv
module tb_tmr8_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       wave_a, wave_b, irq;

    int checks = 0;
    int failures = 0;

    tmr8_pwm dut (
        .clk(clk), .rst_n(rst_n), .presc_tick(presc_tick), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            presc_tick = 1'b1;
            @(negedge clk);
            presc_tick = 1'b0;
        end
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ext_clk = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 register reset", v, 0);
        end
        check("R1 wave_a reset", int'(wave_a), 0);
        check("R1 wave_b reset", int'(wave_b), 0);
        check("R1 irq reset", int'(irq), 0);
        wr(3'd1, 8'h80);
        wr(3'd2, 8'h80);
    endtask

    task automatic t_clock_sel;
        int v;
        ticks(5);
        rd(3'd0, v); check("R2 stopped counter", v, 0);
        wr(3'd3, 8'h04);
        ticks(10);
        rd(3'd0, v); check("R2 prescaler count", v, 10);
    endtask

    task automatic t_wrap;
        int v;
        wr(3'd4, 8'h07);
        wr(3'd0, 8'hFE);
        ticks(1);
        rd(3'd4, v); check("R4 no early overflow", v, 0);
        ticks(1);
        rd(3'd0, v); check("R4 wrap to zero", v, 0);
        rd(3'd4, v); check("R4 overflow flag", v, 1);
    endtask

    task automatic t_flags;
        int v;
        check("R10 irq masked off", int'(irq), 0);
        wr(3'd5, 8'h01);
        check("R10 irq enabled", int'(irq), 1);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R10 flag cleared", v, 0);
        check("R10 irq after clear", int'(irq), 0);
    endtask

    task automatic t_ctc;
        int v;
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h01);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h05);
        ticks(2);
        rd(3'd0, v); check("R5 ctc mid count", v, 2);
        check("R6 wave_b toggled", int'(wave_b), 1);
        ticks(2);
        rd(3'd0, v); check("R5 ctc cleared", v, 0);
        check("R5 wave_a toggled", int'(wave_a), 1);
        rd(3'd4, v); check("R5 R6 match flags", v, 6);
        ticks(4);
        rd(3'd0, v); check("R5 second period", v, 0);
        check("R5 wave_a back", int'(wave_a), 0);
        check("R6 wave_b back", int'(wave_b), 0);
    endtask

    task automatic t_block;
        int v;
        wr(3'd3, 8'h04);
        wr(3'd4, 8'h07);
        wr(3'd0, 8'h03);
        ticks(1);
        rd(3'd0, v); check("R11 count after write", v, 4);
        rd(3'd4, v); check("R11 match blocked", v & 2, 0);
        check("R11 wave_a unchanged", int'(wave_a), 0);
        wr(3'd0, 8'h02);
        ticks(2);
        rd(3'd4, v); check("R11 match after block", v & 2, 2);
        check("R11 wave_a toggled later", int'(wave_a), 1);
    endtask

    task automatic t_pwm_full;
        int v;
        wr(3'd3, 8'h06);
        wr(3'd0, 8'hFD);
        ticks(2);
        rd(3'd0, v); check("R7 full ceiling reached", v, 8'hFF);
        ticks(2);
        rd(3'd0, v); check("R7 full count down", v, 8'hFD);
    endtask

    task automatic t_pwm_var;
        int v;
        wr(3'd3, 8'h04);
        wr(3'd1, 8'h04);
        wr(3'd2, 8'h02);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h07);
        wr(3'd3, 8'h07);
        ticks(4);
        rd(3'd0, v); check("R7 var ceiling", v, 4);
        ticks(1);
        rd(3'd0, v); check("R7 turn down", v, 3);
        check("R8 wave_a clear on up match", int'(wave_a), 0);
        ticks(2);
        check("R8 wave_b set on down match", int'(wave_b), 1);
        ticks(1);
        rd(3'd0, v); check("R7 bottom", v, 0);
        rd(3'd4, v); check("R7 bottom overflow and matches", v, 7);
        ticks(3);
        check("R8 wave_b clear on up match", int'(wave_b), 0);
        wr(3'd2, 8'h03);
        rd(3'd2, v); check("R9 buffered readback", v, 3);
        ticks(1);
        check("R9 old compare still active", int'(wave_b), 0);
        ticks(2);
        check("R9 new compare after ceiling", int'(wave_b), 1);
    endtask

    task automatic t_ext;
        int v;
        wr(3'd3, 8'h08);
        wr(3'd0, 8'h00);
        ext_pulses(3);
        rd(3'd0, v); check("R3 rising edges", v, 3);
        ticks(2);
        rd(3'd0, v); check("R3 prescaler ignored", v, 3);
        wr(3'd3, 8'h0C);
        ext_pulses(2);
        rd(3'd0, v); check("R3 falling edges", v, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_clock_sel;
        t_wrap;
        t_flags;
        t_ctc;
        t_block;
        t_pwm_full;
        t_pwm_var;
        t_ext;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule